// File: doc/BRIEF.md
# Level-Gated Interrupt Acceptance Arbiter

This block sits between an external interrupt controller and the trap logic of a processor core. The controller has already picked one pending request. The arbiter weighs that request against two bus-fault non-maskable events, which arrive when a load or store response comes back with an error. Each cycle it decides whether to take the store fault, take the load fault, take the external request, or take nothing.

The external request is let through only when three things hold: interrupts are globally enabled, the core is not halted for debugging, and the request's level is strictly above the level of the handler now running. This check gives nested preemption. On acceptance the block produces a registered strobe, a cause code, the vectoring flag and the level the core should adopt. The request line is level-sensitive, so it is evaluated again on every cycle until software clears it at its source.

Top module: `irq_arb_top`

## Requirements
- R1: While reset is high, and on the first cycle after it, `take_o` and `take_nmi_o` are 0, and `cause_o`, `shv_o` and `level_o` are 0.
- R2: When `nmi_store_i` is high, outside debug mode, the next cycle shows `take_o`=1, `take_nmi_o`=1 and `cause_o`=1025 (2^ID_W+1). This holds even if `nmi_load_i` or an external request is present in the same cycle.
- R3: When `nmi_load_i` is high and `nmi_store_i` is low, outside debug mode, the next cycle shows `take_o`=1, `take_nmi_o`=1 and `cause_o`=1024 (2^ID_W).
- R4: When a non-maskable event is taken, `shv_o` is 0, `level_o` equals the `active_level_i` sampled in that cycle, and any external request in the same cycle is not taken.
- R5: An external request is taken when all of these hold: `ext_req_i`=1, `mie_i`=1, `debug_i`=0, no non-maskable event, and `ext_level_i` > `active_level_i` (unsigned). The next cycle then shows `take_o`=1, `take_nmi_o`=0, `cause_o` = the ID zero-extended (0..1023), `shv_o` = `ext_shv_i` and `level_o` = `ext_level_i`.
- R6: An external request whose level is equal to or below `active_level_i` is not taken.
- R7: With `mie_i`=0, external requests are not taken, and non-maskable events are still taken.
- R8: With `debug_i`=1, nothing is taken, including non-maskable events.
- R9: In a cycle after an input cycle with no acceptance, `take_o` and `take_nmi_o` are 0, and `cause_o`, `shv_o` and `level_o` keep their last accepted values. Every output changes exactly one clock after the inputs that cause the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_req_i | input | 1 | Pre-selected external request, level-sensitive |
| ext_id_i | input | ID_W | External interrupt identifier |
| ext_level_i | input | LVL_W | Level of the external request |
| ext_shv_i | input | 1 | Hardware vectoring wanted for the request |
| mie_i | input | 1 | Global interrupt enable |
| active_level_i | input | LVL_W | Level of the handler currently running |
| debug_i | input | 1 | Core is in debug mode |
| nmi_load_i | input | 1 | Load response returned a bus error |
| nmi_store_i | input | 1 | Store response returned a bus error |
| take_o | output | 1 | One-cycle acceptance strobe |
| take_nmi_o | output | 1 | Accepted source is a non-maskable event |
| cause_o | output | ID_W+1 | Cause code of the last acceptance |
| shv_o | output | 1 | Vectoring flag of the last acceptance |
| level_o | output | LVL_W | Level to adopt after the last acceptance |

## Verification
The assertions assume that every input is a known value at each rising edge, and that the inputs change only between edges. They also assume `active_level_i` is a plain unsigned value with no relation to earlier acceptances, because this block keeps no memory of levels.

The stimulus meets these assumptions by driving all inputs on the falling edge. Directed vectors cover each rule: the fault ordering, the level boundaries one above, equal to and one below the active level, the enable gate and the debug gate. Random vectors follow, with the active level drawn from the whole range.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

    localparam int unsigned DEF_ID_W  = 10;
    localparam int unsigned DEF_LVL_W = 8;

    typedef enum logic [1:0] {
        SRC_NONE  = 2'd0,
        SRC_STORE = 2'd1,
        SRC_LOAD  = 2'd2,
        SRC_EXT   = 2'd3
    } src_e;

    typedef struct packed {
        logic take;
        logic nmi;
        src_e src;
    } pick_t;

    // Fixed ranking: debug silences all, store fault, load fault, external.
    function automatic pick_t rank_sources(input logic dbg,
                                           input logic st,
                                           input logic ld,
                                           input logic ext_ok);
        pick_t p;
        p = '{take: 1'b0, nmi: 1'b0, src: SRC_NONE};
        if (!dbg) begin
            if (st)          p = '{take: 1'b1, nmi: 1'b1, src: SRC_STORE};
            else if (ld)     p = '{take: 1'b1, nmi: 1'b1, src: SRC_LOAD};
            else if (ext_ok) p = '{take: 1'b1, nmi: 1'b0, src: SRC_EXT};
        end
        return p;
    endfunction

endpackage

// File: rtl/irq_ext_qual.sv
module irq_ext_qual #(
    parameter int unsigned LVL_W = 8
) (
    input  logic             req,
    input  logic             glob_en,
    input  logic [LVL_W-1:0] req_level,
    input  logic [LVL_W-1:0] cur_level,
    output logic             ok
);
    // Strictly higher level preempts; equal level does not.
    always_comb begin
        ok = req && glob_en && (req_level > cur_level);
    end
endmodule

// File: rtl/irq_src_pick.sv
module irq_src_pick
    import irq_arb_pkg::*;
(
    input  logic  dbg,
    input  logic  nmi_st,
    input  logic  nmi_ld,
    input  logic  ext_ok,
    output pick_t pick
);
    always_comb begin
        pick = rank_sources(dbg, nmi_st, nmi_ld, ext_ok);
    end
endmodule

// File: rtl/irq_arb_top.sv
module irq_arb_top
    import irq_arb_pkg::*;
#(
    parameter int unsigned ID_W  = DEF_ID_W,
    parameter int unsigned LVL_W = DEF_LVL_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ext_req_i,
    input  logic [ID_W-1:0]    ext_id_i,
    input  logic [LVL_W-1:0]   ext_level_i,
    input  logic               ext_shv_i,
    input  logic               mie_i,
    input  logic [LVL_W-1:0]   active_level_i,
    input  logic               debug_i,
    input  logic               nmi_load_i,
    input  logic               nmi_store_i,
    output logic               take_o,
    output logic               take_nmi_o,
    output logic [ID_W:0]      cause_o,
    output logic               shv_o,
    output logic [LVL_W-1:0]   level_o
);
    localparam int unsigned CAUSE_W = ID_W + 1;
    localparam logic [CAUSE_W-1:0] CAUSE_LOAD  = {1'b1, {ID_W{1'b0}}};
    localparam logic [CAUSE_W-1:0] CAUSE_STORE = CAUSE_LOAD | CAUSE_W'(1);

    logic  ext_ok;
    pick_t pick;
    logic [CAUSE_W-1:0] cause_d;
    logic               shv_d;
    logic [LVL_W-1:0]   level_d;

    irq_ext_qual #(.LVL_W(LVL_W)) u_qual (
        .req       (ext_req_i),
        .glob_en   (mie_i),
        .req_level (ext_level_i),
        .cur_level (active_level_i),
        .ok        (ext_ok)
    );

    irq_src_pick u_pick (
        .dbg    (debug_i),
        .nmi_st (nmi_store_i),
        .nmi_ld (nmi_load_i),
        .ext_ok (ext_ok),
        .pick   (pick)
    );

    always_comb begin
        cause_d = cause_o;
        shv_d   = shv_o;
        level_d = level_o;
        unique case (pick.src)
            SRC_STORE: begin
                cause_d = CAUSE_STORE;
                shv_d   = 1'b0;
                level_d = active_level_i;
            end
            SRC_LOAD: begin
                cause_d = CAUSE_LOAD;
                shv_d   = 1'b0;
                level_d = active_level_i;
            end
            SRC_EXT: begin
                cause_d = {1'b0, ext_id_i};
                shv_d   = ext_shv_i;
                level_d = ext_level_i;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            take_o     <= 1'b0;
            take_nmi_o <= 1'b0;
            cause_o    <= '0;
            shv_o      <= 1'b0;
            level_o    <= '0;
        end else begin
            take_o     <= pick.take;
            take_nmi_o <= pick.nmi;
            cause_o    <= cause_d;
            shv_o      <= shv_d;
            level_o    <= level_d;
        end
    end

    // Store fault wins over everything outside debug.
    p_store_first_r2: assert property (@(posedge clk) disable iff (rst)
        (nmi_store_i && !debug_i) |=> (take_o && take_nmi_o && cause_o == CAUSE_STORE));

    // Non-maskable acceptance never carries vectoring.
    p_nmi_no_shv_r4: assert property (@(posedge clk) disable iff (rst)
        (take_o && take_nmi_o) |-> !shv_o);

    // Qualified external request is taken with its own ID and level.
    p_ext_take_r5: assert property (@(posedge clk) disable iff (rst)
        (ext_req_i && mie_i && !debug_i && !nmi_load_i && !nmi_store_i
         && (ext_level_i > active_level_i))
        |=> (take_o && !take_nmi_o && cause_o == {1'b0, $past(ext_id_i)}
             && level_o == $past(ext_level_i)));

    // No preemption at equal or lower level.
    p_level_gate_r6: assert property (@(posedge clk) disable iff (rst)
        (!nmi_load_i && !nmi_store_i && (ext_level_i <= active_level_i)) |=> !take_o);

    // Global enable low blocks external requests.
    p_mie_gate_r7: assert property (@(posedge clk) disable iff (rst)
        (!mie_i && !nmi_load_i && !nmi_store_i) |=> !take_o);

    // Debug mode silences every source.
    p_debug_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        debug_i |=> !take_o);

    // Payload holds when nothing is taken.
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!take_o && !$past(rst)) |-> ($stable(cause_o) && $stable(level_o) && $stable(shv_o)));

endmodule

// File: tb/irq_arb_top_tb_top.sv
`timescale 1ns/1ps
module irq_arb_top_tb_top;
    localparam int ID_W  = 10;
    localparam int LVL_W = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ext_req_i = 0, ext_shv_i = 0, mie_i = 0, debug_i = 0;
    logic nmi_load_i = 0, nmi_store_i = 0;
    logic [ID_W-1:0]  ext_id_i = '0;
    logic [LVL_W-1:0] ext_level_i = '0, active_level_i = '0;
    logic take_o, take_nmi_o, shv_o;
    logic [ID_W:0] cause_o;
    logic [LVL_W-1:0] level_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // reference state
    bit e_take, e_nmi, e_shv;
    int e_cause, e_level;

    always #5 clk = ~clk;

    irq_arb_top #(.ID_W(ID_W), .LVL_W(LVL_W)) dut_i (
        .clk(clk), .rst(rst), .ext_req_i(ext_req_i), .ext_id_i(ext_id_i),
        .ext_level_i(ext_level_i), .ext_shv_i(ext_shv_i), .mie_i(mie_i),
        .active_level_i(active_level_i), .debug_i(debug_i),
        .nmi_load_i(nmi_load_i), .nmi_store_i(nmi_store_i),
        .take_o(take_o), .take_nmi_o(take_nmi_o), .cause_o(cause_o),
        .shv_o(shv_o), .level_o(level_o)
    );

    task automatic compare(input string tag);
        checks++;
        if (take_o !== e_take || take_nmi_o !== e_nmi || shv_o !== e_shv ||
            int'(cause_o) != e_cause || int'(level_o) != e_level) begin
            errors++;
            $display("FAIL %s: got take=%0b nmi=%0b cause=%0d shv=%0b lvl=%0d exp take=%0b nmi=%0b cause=%0d shv=%0b lvl=%0d",
                     tag, take_o, take_nmi_o, cause_o, shv_o, level_o,
                     e_take, e_nmi, e_cause, e_shv, e_level);
        end
    endtask

    // behavioural model of one input cycle
    task automatic model();
        e_take = 0; e_nmi = 0;
        if (debug_i) return;
        if (nmi_store_i || nmi_load_i) begin
            e_take = 1; e_nmi = 1; e_shv = 0;
            e_cause = nmi_store_i ? (1 << ID_W) + 1 : (1 << ID_W);
            e_level = active_level_i;
        end else if (ext_req_i && mie_i && ext_level_i > active_level_i) begin
            e_take = 1; e_cause = ext_id_i; e_shv = ext_shv_i; e_level = ext_level_i;
        end
    endtask

    task automatic drive(input string tag, input bit rq, input int id, input int lv,
                         input bit sh, input bit me, input int act, input bit dg,
                         input bit ld, input bit st);
        ext_req_i = rq; ext_id_i = ID_W'(id); ext_level_i = LVL_W'(lv);
        ext_shv_i = sh; mie_i = me; active_level_i = LVL_W'(act);
        debug_i = dg; nmi_load_i = ld; nmi_store_i = st;
        model();
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        e_take = 0; e_nmi = 0; e_shv = 0; e_cause = 0; e_level = 0;
        repeat (3) @(negedge clk);
        compare("R1");
        // request present during reset must not leak out
        ext_req_i = 1; mie_i = 1; ext_level_i = 8'd9; ext_id_i = 10'd33;
        @(negedge clk);
        compare("R1");
        rst = 1'b0;
        drive("R1", 0, 0, 0, 0, 0, 0, 0, 0, 0);
        drive("R2", 1, 7, 200, 1, 1, 3, 0, 1, 1);
        drive("R3", 0, 0, 0, 0, 1, 17, 0, 1, 0);
        drive("R4", 1, 500, 250, 1, 1, 4, 0, 1, 0);
        drive("R5", 1, 1023, 6, 1, 1, 5, 0, 0, 0);
        drive("R5", 1, 0, 255, 0, 1, 254, 0, 0, 0);
        drive("R6", 1, 12, 5, 1, 1, 5, 0, 0, 0);
        drive("R6", 1, 12, 4, 1, 1, 5, 0, 0, 0);
        drive("R9", 0, 12, 40, 0, 1, 5, 0, 0, 0);
        drive("R7", 1, 77, 90, 1, 0, 1, 0, 0, 0);
        drive("R7", 1, 77, 90, 1, 0, 1, 0, 0, 1);
        drive("R8", 1, 88, 90, 1, 1, 1, 1, 0, 0);
        drive("R8", 0, 0, 0, 0, 1, 1, 1, 1, 1);
        drive("R9", 1, 321, 128, 1, 1, 0, 0, 0, 0);
        drive("R9", 1, 321, 128, 1, 1, 0, 0, 0, 0);
        for (int i = 0; i < 400; i++) begin
            drive("R5", bit'($urandom_range(0, 1)), int'($urandom_range(0, 1023)),
                  int'($urandom_range(0, 255)), bit'($urandom_range(0, 1)),
                  bit'($urandom_range(0, 3) != 0), int'($urandom_range(0, 255)),
                  bit'($urandom_range(0, 7) == 0), bit'($urandom_range(0, 5) == 0),
                  bit'($urandom_range(0, 7) == 0));
        end
        finished = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #200000;
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got hung run exp completion");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule